// File: doc/BRIEF.md
# Sixty-Four Source Prioritised Interrupt Controller

This block gathers 64 interrupt inputs into a single request line for a processor. Every source has its own configuration word that chooses between edge and level triggering and gives it a priority level. A source whose trigger condition holds is pending. A pending source that is also unmasked is eligible. The controller picks the eligible source with the highest priority and raises its request output when that source outranks everything currently being serviced.

Software reaches the block over a simple single-cycle register bus. The bus has a word address, a write enable, 32-bit write data and registered read data. Unmasking and masking go through separate write-one-to-set and write-one-to-clear registers, one of each per 32-source bank.

Interrupt service works as follows:
- A read of the vector register returns the winning source and claims it as in service.
- A write to the end-of-interrupt register retires the highest-priority source in service.
- A soft reset register clears all state.
- A control bit gates request generation as a whole.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After the hardware reset every source is masked, configuration words read 0, the control word reads 0, `irq_o` is low and a vector read returns 64.
- R2: Writing 1s to word 0x10+b unmasks the sources of bank b, and writing 1s to word 0x18+b masks them. Bank b covers sources 32b..32b+31, and bit k of the bank is source 32b+k. Bits written 0 leave the mask unchanged. Both words read back the current unmask state of the bank.
- R3: The configuration word of source n is at word address 0x40+2n. Bit 0 selects edge triggering (1) or level triggering (0), and bits 10:8 hold the priority, where 7 is the most urgent. Reads return only those bits.
- R4: A level source is pending while its input is high. An edge source becomes pending on a rising edge of its input and stays pending after the input falls. Word 0x20+b reads the pending state of bank b.
- R5: A read of word 0x02 returns the eligible source with the highest priority, with ties going to the lower source number. It returns 64 when no source may be granted.
- R6: `irq_o` rises one cycle after a source becomes grantable. A source is grantable when bit 0 of control word 0x00 is set, and either no source is in service or its priority is strictly above that of every source in service.
- R7: A vector read that returns a source number marks that source as in service and clears its edge latch.
- R8: Any write to word 0x03 releases the highest-priority source in service, and only that one.
- R9: Writing an edge source's configuration word with bit 0 clear discards its latched edge, and restoring the edge bit afterwards does not bring the edge back.
- R10: Writing word 0x01 with bit 0 set returns all masks, configuration words, edge latches, in-service state and the control bit to zero. A write with bit 0 clear has no effect.
- R11: A masked source is never granted and never raises `irq_o`, but its pending state stays visible in the pending words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Interrupt source inputs, bit n is source n |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach from the ports is nested service. Several sources are in service at once, and a more urgent one must preempt while an equal-priority one must stay blocked. An end-of-interrupt must then retire only the top in-service source while the others remain.

Directed sequences build this stack on purpose: a low-priority claim, then a preempting claim, then releases in order. A level source that is still high after its release must win again.

Constrained random traffic then mixes input toggles, mask writes, configuration rewrites, claims and releases over a small number of active sources. This lets in-service sets of two or three sources arise with varied priorities, and a bench model predicts every vector and request level.

// File: rtl/ic_pkg.sv
package ic_pkg;
  // word addresses of the register map
  localparam int A_CTRL     = 'h00;
  localparam int A_RST      = 'h01;
  localparam int A_VEC      = 'h02;
  localparam int A_EOI      = 'h03;
  localparam int A_SET_BASE = 'h10;
  localparam int A_CLR_BASE = 'h18;
  localparam int A_PND_BASE = 'h20;
  localparam int A_CFG_BASE = 'h40;
  localparam int CFG_STRIDE = 2;
  // configuration word fields
  localparam int CFG_EDGE_BIT = 0;
  localparam int CFG_PRIO_LSB = 8;
endpackage

// File: rtl/ic_rst_sync.sv
module ic_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ic_src_slice.sv
module ic_src_slice #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              src_i,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              cfg_we,
  input  logic              cfg_edge_d,
  input  logic [PRIO_W-1:0] cfg_prio_d,
  input  logic              claim,
  output logic              en_o,
  output logic              edge_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              pend_o
);
  logic              src_q;
  logic              en_q, en_d;
  logic              edge_q, edge_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              latch_q, latch_d;
  logic              rise;

  assign rise = src_i & ~src_q;

  always_comb begin
    en_d    = en_q;
    edge_d  = edge_q;
    prio_d  = prio_q;
    latch_d = latch_q;
    if (srst) begin
      en_d    = 1'b0;
      edge_d  = 1'b0;
      prio_d  = '0;
      latch_d = 1'b0;
    end else begin
      if (en_set)      en_d = 1'b1;
      else if (en_clr) en_d = 1'b0;
      if (cfg_we) begin
        edge_d = cfg_edge_d;
        prio_d = cfg_prio_d;
      end
      // order: a config write with the edge bit clear wins, then a new edge, then a claim
      if (cfg_we && !cfg_edge_d)  latch_d = 1'b0;
      else if (edge_q && rise)    latch_d = 1'b1;
      else if (claim)             latch_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      en_q    <= 1'b0;
      edge_q  <= 1'b0;
      prio_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      src_q   <= src_i;
      en_q    <= en_d;
      edge_q  <= edge_d;
      prio_q  <= prio_d;
      latch_q <= latch_d;
    end
  end

  assign en_o   = en_q;
  assign edge_o = edge_q;
  assign prio_o = prio_q;
  assign pend_o = edge_q ? latch_q : src_q;

  assert_unmask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_o);
  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set && !srst) |=> !en_o);
  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && rise && !cfg_we && !srst) |=> pend_o);
  assert_claim_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !(edge_q && rise)) |=> !latch_q);
  assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_edge_d) |=> !latch_q);
endmodule

// File: rtl/ic_prio_pick.sv
module ic_prio_pick #(
  parameter int N      = 64,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 7
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                valid,
  output logic [IDX_W-1:0]    idx,
  output logic [PRIO_W-1:0]   prio
);
  // descending scan with >= so the lowest index wins among equals
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    prio  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!valid || prio_flat[i*PRIO_W +: PRIO_W] >= prio)) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
        prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int NUM_BANK = NUM_SRC / DATA_W;
  localparam int IDX_W    = $clog2(NUM_SRC + 1);

  logic rst_n_s;
  ic_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  logic wr, rd, srst, eoi, vec_rd;
  assign wr     = bus_en & bus_we;
  assign rd     = bus_en & ~bus_we;
  assign srst   = wr && (bus_addr == ADDR_W'(A_RST)) && bus_wdata[0];
  assign eoi    = wr && (bus_addr == ADDR_W'(A_EOI));
  assign vec_rd = rd && (bus_addr == ADDR_W'(A_VEC));

  logic [NUM_SRC-1:0]        en_vec, edge_vec, pend_vec, claim_vec, rel_vec;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      gen_en_q, gen_en_d;
  logic [NUM_SRC-1:0]        insvc_q, insvc_d;
  logic                      irq_q, irq_d;
  logic [DATA_W-1:0]         rdata_q, rdata_d, rd_mux;

  logic              win_valid, svc_valid, grant, claim_ok;
  logic [IDX_W-1:0]  win_idx, svc_idx, vec_val;
  logic [PRIO_W-1:0] win_prio, svc_prio;

  // per-source slices with their bus strobes
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int BK = i / DATA_W;
    localparam int BT = i % DATA_W;
    logic set_s, clr_s, cfg_s;
    assign set_s = wr && (bus_addr == ADDR_W'(A_SET_BASE + BK)) && bus_wdata[BT];
    assign clr_s = wr && (bus_addr == ADDR_W'(A_CLR_BASE + BK)) && bus_wdata[BT];
    assign cfg_s = wr && (bus_addr == ADDR_W'(A_CFG_BASE + CFG_STRIDE * i));
    assign claim_vec[i] = claim_ok && (win_idx == IDX_W'(i));
    assign rel_vec[i]   = eoi && svc_valid && (svc_idx == IDX_W'(i));

    ic_src_slice #(.PRIO_W(PRIO_W)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .srst       (srst),
      .src_i      (src_i[i]),
      .en_set     (set_s),
      .en_clr     (clr_s),
      .cfg_we     (cfg_s),
      .cfg_edge_d (bus_wdata[CFG_EDGE_BIT]),
      .cfg_prio_d (bus_wdata[CFG_PRIO_LSB +: PRIO_W]),
      .claim      (claim_vec[i]),
      .en_o       (en_vec[i]),
      .edge_o     (edge_vec[i]),
      .prio_o     (prio_flat[i*PRIO_W +: PRIO_W]),
      .pend_o     (pend_vec[i])
    );
  end

  // winner among eligible sources, and top of the in-service set
  ic_prio_pick #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_win (
    .req(pend_vec & en_vec), .prio_flat(prio_flat),
    .valid(win_valid), .idx(win_idx), .prio(win_prio));

  ic_prio_pick #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_svc (
    .req(insvc_q), .prio_flat(prio_flat),
    .valid(svc_valid), .idx(svc_idx), .prio(svc_prio));

  assign grant    = gen_en_q && win_valid && (!svc_valid || (win_prio > svc_prio));
  assign claim_ok = vec_rd && grant;
  assign vec_val  = grant ? win_idx : IDX_W'(NUM_SRC);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) rd_mux[0] = gen_en_q;
    if (bus_addr == ADDR_W'(A_VEC))  rd_mux = DATA_W'(vec_val);
    for (int b = 0; b < NUM_BANK; b++) begin
      if (bus_addr == ADDR_W'(A_SET_BASE + b) || bus_addr == ADDR_W'(A_CLR_BASE + b))
        rd_mux = en_vec[b*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(A_PND_BASE + b))
        rd_mux = pend_vec[b*DATA_W +: DATA_W];
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_addr == ADDR_W'(A_CFG_BASE + CFG_STRIDE * i)) begin
        rd_mux[CFG_EDGE_BIT]            = edge_vec[i];
        rd_mux[CFG_PRIO_LSB +: PRIO_W]  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    gen_en_d = gen_en_q;
    insvc_d  = (insvc_q | claim_vec) & ~rel_vec;
    irq_d    = grant;
    rdata_d  = rdata_q;
    if (wr && (bus_addr == ADDR_W'(A_CTRL))) gen_en_d = bus_wdata[0];
    if (rd) rdata_d = rd_mux;
    if (srst) begin
      gen_en_d = 1'b0;
      insvc_d  = '0;
      irq_d    = 1'b0;
      rdata_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      gen_en_q <= 1'b0;
      insvc_q  <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      gen_en_q <= gen_en_d;
      insvc_q  <= insvc_d;
      irq_q    <= irq_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  assert_gen_gate_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !gen_en_q |=> !irq_o);
  assert_claim_count_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    claim_ok |=> ($countones(insvc_q) == $past($countones(insvc_q)) + 1));
  assert_eoi_one_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eoi && (insvc_q != '0)) |=> ($countones(insvc_q) == $past($countones(insvc_q)) - 1));
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    srst |=> (en_vec == '0 && insvc_q == '0 && !gen_en_q && !irq_o));
  assert_masked_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    claim_ok |-> en_vec[win_idx[IDX_W-2:0]]);
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int N = 64;
  localparam int VEC_NONE = 64;
  // register map as stated in the requirements
  localparam int W_CTRL = 'h00, W_RST = 'h01, W_VEC = 'h02, W_EOI = 'h03;
  localparam int W_SET = 'h10, W_CLR = 'h18, W_PND = 'h20, W_CFG = 'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  prio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  initial forever begin
    @(posedge clk); cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // bench model
  bit m_en[N], m_edge[N], m_latch[N], m_svc[N], m_src[N];
  int m_prio[N];
  bit m_gen;

  function automatic bit pend(int i);
    return m_edge[i] ? m_latch[i] : m_src[i];
  endfunction

  function automatic int top_elig();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (pend(i) && m_en[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic int top_svc();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_svc[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic int exp_vec();
    int w = top_elig();
    int s = top_svc();
    if (m_gen && w >= 0 && (s < 0 || m_prio[w] > m_prio[s])) return w;
    return VEC_NONE;
  endfunction

  function automatic logic [31:0] bank_word(int b, bit sel_pend);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) v[k] = sel_pend ? pend(b*32+k) : m_en[b*32+k];
    return v;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_edge[i] = 0; m_latch[i] = 0; m_svc[i] = 0; m_prio[i] = 0;
    end
    m_gen = 0;
  endfunction

  function automatic void model_wr(int a, logic [31:0] d);
    int s;
    if (a == W_CTRL) m_gen = d[0];
    if (a == W_RST && d[0]) model_reset();
    if (a == W_EOI) begin s = top_svc(); if (s >= 0) m_svc[s] = 0; end
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 32; k++) begin
        if (a == W_SET + b && d[k]) m_en[b*32+k] = 1;
        if (a == W_CLR + b && d[k]) m_en[b*32+k] = 0;
      end
    if (a >= W_CFG && a < W_CFG + 2*N && a % 2 == 0) begin
      s = (a - W_CFG) / 2;
      m_edge[s] = d[0]; m_prio[s] = int'(d[10:8]);
      if (!d[0]) m_latch[s] = 0;
    end
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 0; bus_we = 0;
    model_wr(a, d);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 8'(a);
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic set_src(int i, bit v);
    @(negedge clk);
    src_i[i] = v;
    if (m_edge[i] && v && !m_src[i]) m_latch[i] = 1;
    m_src[i] = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_irq(string tag);
    @(posedge clk); @(negedge clk);
    check(tag, 32'(irq_o), 32'(m_gen && exp_vec() != VEC_NONE));
  endtask

  task automatic chk_vec(string tag);
    logic [31:0] got;
    int e = exp_vec();
    rd(W_VEC, got);
    check(tag, got, 32'(e));
    if (e != VEC_NONE) begin m_svc[e] = 1; m_latch[e] = 0; end
  endtask

  task automatic chk_rd(string tag, int a, logic [31:0] exp);
    logic [31:0] got;
    rd(a, got);
    check(tag, got, exp);
  endtask

  task automatic chk_banks(string tag);
    for (int b = 0; b < 2; b++) begin
      chk_rd(tag, W_SET + b, bank_word(b, 0));
      chk_rd(tag, W_PND + b, bank_word(b, 1));
    end
  endtask

  initial begin
    logic [31:0] r;
    model_reset();
    for (int i = 0; i < N; i++) m_src[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", 32'(irq_o), 0);
    chk_rd("R1 control word", W_CTRL, 0);
    chk_rd("R1 mask bank 0", W_SET, 0);
    chk_rd("R1 mask bank 1", W_CLR + 1, 0);
    chk_rd("R1 cfg word", W_CFG + 2*17, 0);
    chk_rd("R1 spurious vector", W_VEC, VEC_NONE);

    // R3 configuration word layout
    wr(W_CFG + 2*5, 32'h0000_0501);
    chk_rd("R3 cfg readback", W_CFG + 2*5, 32'h501);
    wr(W_CFG + 2*40, 32'hFFFF_FFFF);
    chk_rd("R3 cfg masked readback", W_CFG + 2*40, 32'h701);
    wr(W_CFG + 2*40, 32'h0000_0700);

    // R2 set/clear banks
    wr(W_SET + 1, 32'h100);
    chk_rd("R2 set bank 1", W_SET + 1, 32'h100);
    wr(W_CLR + 1, 32'h0);
    chk_rd("R2 zero clear no effect", W_CLR + 1, 32'h100);
    wr(W_SET, 32'h20);
    chk_rd("R2 clear-word readback", W_CLR, 32'h20);

    // R6 generation gate
    set_src(40, 1);
    chk_irq("R6 gated while disabled");
    chk_rd("R6 vector while disabled", W_VEC, VEC_NONE);
    wr(W_CTRL, 1);
    chk_irq("R6 request after enable");
    chk_vec("R5 vector picks 40");
    chk_irq("R6 request drops in service");
    // R4 edge latch holds, nesting blocks lower priority
    set_src(5, 1);
    set_src(5, 0);
    chk_rd("R4 edge latch held", W_PND, 32'h20);
    chk_irq("R6 lower priority blocked");
    wr(W_EOI, 32'h1234);
    chk_irq("R8 release re-arms level 40");
    chk_vec("R5 level 40 wins again");
    wr(W_EOI, 0);
    // R11 masked source keeps pending
    wr(W_CLR + 1, 32'h100);
    chk_rd("R11 masked pending visible", W_PND + 1, 32'h100);
    chk_vec("R11 masked source skipped");
    chk_rd("R7 edge latch cleared by claim", W_PND, 32'h0);
    wr(W_EOI, 0);
    set_src(40, 0);

    // R5 tie goes to lower index
    wr(W_CFG + 2*12, 32'h300);
    wr(W_CFG + 2*10, 32'h300);
    wr(W_SET, 32'h1400);
    set_src(12, 1);
    set_src(10, 1);
    chk_vec("R5 tie lowest index");
    chk_irq("R6 equal priority blocked");
    wr(W_EOI, 0);
    set_src(10, 0); set_src(12, 0);

    // R9 edge discard by config rewrite
    wr(W_CFG + 2*20, 32'h201);
    wr(W_SET, 32'h10_0000);
    set_src(20, 1); set_src(20, 0);
    chk_rd("R9 latched before rewrite", W_PND, 32'h10_0000);
    wr(W_CFG + 2*20, 32'h200);
    wr(W_CFG + 2*20, 32'h201);
    chk_rd("R9 latch discarded", W_PND, 32'h0);
    chk_vec("R9 no grant after discard");

    // R10 soft reset
    wr(W_RST, 32'hFFFF_FFFE);
    chk_rd("R10 bit0 clear no effect", W_CTRL, 1);
    wr(W_RST, 1);
    chk_rd("R10 control cleared", W_CTRL, 0);
    chk_rd("R10 masks cleared", W_SET, 0);
    chk_rd("R10 cfg cleared", W_CFG + 2*20, 0);
    chk_irq("R10 request low");

    // R8 nested service
    wr(W_CFG + 2*1, 32'h100);
    wr(W_CFG + 2*2, 32'h600);
    wr(W_SET, 32'h6);
    wr(W_CTRL, 1);
    set_src(1, 1);
    chk_vec("R7 claim low priority 1");
    set_src(2, 1);
    chk_irq("R6 preemption by 2");
    chk_vec("R7 claim nested 2");
    wr(W_EOI, 0);
    chk_irq("R8 top released only");
    chk_vec("R8 2 regranted above 1");
    set_src(2, 0);
    wr(W_EOI, 0);
    chk_irq("R8 1 still in service");
    wr(W_EOI, 0);
    chk_irq("R8 all released");
    chk_vec("R8 level 1 regranted");
    wr(W_EOI, 0);
    set_src(1, 0);

    // random phase
    void'($urandom(32'h00C0FFEE));
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 8);
      int s  = int'($urandom % 12) * 5;
      int b  = int'($urandom % 2);
      case (op)
        0, 1: set_src(s, !m_src[s]);
        2:    wr(W_SET + b, $urandom & $urandom);
        3:    wr(W_CLR + b, $urandom & $urandom & $urandom);
        4:    wr(W_CFG + 2*s, $urandom);
        5, 6: chk_vec("R5 random vector");
        default: wr(W_EOI, $urandom);
      endcase
      chk_irq("R6 random request");
      if (it % 60 == 0) chk_banks("R4 random banks");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule